// File: doc/BRIEF.md
# USB Host Pipe Freeze and Bank Controller

This block governs one physical pipe of a USB host controller. While the pipe is enabled and not frozen, it asks the transaction engine for an IN or OUT token whenever the data bank it currently points at has been marked ready by software. It then waits for the result of that transaction. An acknowledged transaction consumes the bank. The block clears that bank's ready bit, raises its completion flag and, when two banks are configured, moves on to the other bank. A NAK changes nothing, so the same bank is requested again.

The pipe is stopped by hardware in several cases: when it is enabled, on a STALL handshake, on a pipe error, and when a link power management transaction ends, whether with a handshake or by timing out. Software may also freeze or unfreeze the pipe. A software freeze that arrives while a transaction is outstanding is held back until that transaction's result comes in. The packet engine, the DMA and the descriptor memory sit outside this block. Result codes on `res_code` are ACK = 0, NAK = 1, STALL = 2, pipe error = 3, LPM handshake = 4 and LPM timeout = 5. Codes 6 and 7 end the transaction with no other effect.

Top module: `upipe_ctrl`

## Requirements
- R1: `tok_req` is high exactly when `pipe_en` is 1, the pipe is not frozen, no transaction is outstanding and the ready bit of bank `cur_bank` is set. `tok_grant` while `tok_req` is high starts a transaction, and `tok_req` stays low until that transaction's result arrives.
- R2: `frozen` is 1 after reset and whenever `pipe_en` was 0 in the previous cycle, so a newly enabled pipe starts frozen. Disabling the pipe clears both ready bits, both completion flags, the bank index and any outstanding or pending state.
- R3: A STALL result (code 2) ends the transaction and sets `frozen` in the next cycle.
- R4: A pipe error result (code 3) ends the transaction and sets `frozen` in the next cycle.
- R5: A link power management result, either handshake (code 4) or timeout (code 5), ends the transaction and sets `frozen` in the next cycle.
- R6: `sw_freeze` with no transaction outstanding after the edge sets `frozen` in the next cycle. With a transaction outstanding, `frozen` stays 0 until the result arrives and is 1 in the cycle after it. `sw_unfreeze` clears `frozen` unless a freeze condition occurs in the same cycle.
- R7: An ACK (code 0) clears the ready bit of the current bank and sets that bank's `bank_done` bit. `bank_rdy_set[i]` sets ready bit i and wins over a clear in the same cycle. `done_clr[i]` clears `bank_done[i]` and loses to a set in the same cycle.
- R8: A NAK (code 1) ends the transaction and leaves `frozen`, `cur_bank`, the ready bits and the completion flags unchanged, so the request is raised again.
- R9: With `dual_bank` = 1, each ACK toggles `cur_bank`, and a request is raised only once the new bank is ready.
- R10: With `dual_bank` = 0, `cur_bank` is 0 from the cycle after `dual_bank` is seen low.
- R11: `res_valid` with no transaction outstanding is ignored: frozen state, bank index, ready bits and completion flags are untouched by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_en | input | 1 | Pipe enable |
| dual_bank | input | 1 | 1: two banks alternate, 0: bank 0 only |
| bank_rdy_set | input | 2 | Per-bank ready set pulses from software |
| done_clr | input | 2 | Per-bank completion flag clear pulses |
| sw_freeze | input | 1 | Software freeze request |
| sw_unfreeze | input | 1 | Software unfreeze request |
| tok_grant | input | 1 | Transaction engine accepts the token request |
| res_valid | input | 1 | Transaction result valid |
| res_code | input | 3 | Transaction result code |
| tok_req | output | 1 | Token request to the transaction engine |
| cur_bank | output | 1 | Current bank index |
| frozen | output | 1 | Pipe frozen status |
| bank_rdy | output | 2 | Per-bank ready bits |
| bank_done | output | 2 | Per-bank completion flags |

## Verification
Directed sequences walk the pipe through enable, unfreeze, a NAK retry, ACKs that alternate banks, a freeze raised during an outstanding transaction, and each of the four hardware freeze results. Each of these cases shows whether a result ends, repeats or stops the transfer. Stray results while idle, single-bank operation and disabling in mid-transfer separate ignored inputs from state that must reset. A long run from a fixed seed then mixes grants, weighted result codes, ready and clear pulses and freeze requests. A cycle model in the bench predicts every output. This exposes ordering collisions such as a ready set landing on the cycle its bank is consumed, or a freeze meeting a result in the same cycle.

// File: rtl/upipe_pkg.sv
// Shared constants for the host pipe controller: result codes and bank sizing.
package upipe_pkg;
    localparam int RES_W      = 3;
    localparam int MAX_BANKS  = 2;
    localparam int BANK_IDX_W = $clog2(MAX_BANKS);

    localparam logic [RES_W-1:0] RC_ACK     = 3'd0;
    localparam logic [RES_W-1:0] RC_NAK     = 3'd1;
    localparam logic [RES_W-1:0] RC_STALL   = 3'd2;
    localparam logic [RES_W-1:0] RC_PERR    = 3'd3;
    localparam logic [RES_W-1:0] RC_LPM_HS  = 3'd4;
    localparam logic [RES_W-1:0] RC_LPM_TMO = 3'd5;
endpackage

// File: rtl/upipe_bank_slot.sv
// One data bank's ready bit and completion flag.
// Assumes: consume is a single-cycle pulse for an acknowledged transaction on
// this bank; a software set wins over consume, consume wins over a clear.
module upipe_bank_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic pipe_en,
    input  logic set_rdy,
    input  logic consume,
    input  logic clr_done,
    output logic rdy,
    output logic done
);
    logic rdy_q, done_q;

    // Ready bit: set by software, cleared when the bank is consumed or the pipe is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !pipe_en)  rdy_q <= 1'b0;
        else if (set_rdy)        rdy_q <= 1'b1;
        else if (consume)        rdy_q <= 1'b0;
    end

    // Completion flag: raised on consume, dropped by software clear or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !pipe_en)  done_q <= 1'b0;
        else if (consume)        done_q <= 1'b1;
        else if (clr_done)       done_q <= 1'b0;
    end

    assign rdy  = rdy_q;
    assign done = done_q;

    assert_ack_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && consume && !set_rdy) |=> (!rdy_q && done_q));
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && set_rdy) |=> rdy_q);
endmodule

// File: rtl/upipe_freeze_ctl.sv
// Request, outstanding-transaction and freeze control of one host pipe.
// Assumes: res_valid is only meaningful while a transaction is outstanding;
// tok_grant is only acted on while tok_req is high.
module upipe_freeze_ctl
    import upipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_en,
    input  logic             bank_ready,
    input  logic             tok_grant,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_code,
    input  logic             sw_freeze,
    input  logic             sw_unfreeze,
    output logic             tok_req,
    output logic             frozen,
    output logic             xfer_ack
);
    logic frozen_q, busy_q, pend_q;
    logic fin, hw_frz, start, busy_nx, frz_now;

    // Decode the result of the outstanding transaction and the next busy state.
    always_comb begin
        fin     = busy_q && res_valid;
        hw_frz  = fin && (res_code == RC_STALL  || res_code == RC_PERR ||
                          res_code == RC_LPM_HS || res_code == RC_LPM_TMO);
        start   = tok_req && tok_grant;
        busy_nx = start || (busy_q && !fin);
        frz_now = hw_frz || (fin && pend_q) || (sw_freeze && !busy_nx);
    end

    assign tok_req  = pipe_en && !frozen_q && !busy_q && bank_ready;
    assign xfer_ack = fin && (res_code == RC_ACK);
    assign frozen   = frozen_q;

    // Transaction tracking and deferred software freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || !pipe_en) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            busy_q <= busy_nx;
            pend_q <= fin ? 1'b0 : (pend_q || (sw_freeze && busy_nx));
        end
    end

    // Frozen status: hardware and software freezes win over unfreeze.
    always_ff @(posedge clk) begin
        if (!rst_n || !pipe_en) frozen_q <= 1'b1;
        else if (frz_now)       frozen_q <= 1'b1;
        else if (sw_unfreeze)   frozen_q <= 1'b0;
    end

    assert_no_req_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_q |-> !tok_req);
    assert_no_req_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !tok_req);
    assert_enable_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_en) |-> frozen_q);
    assert_stall_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && fin && res_code == RC_STALL) |=> frozen_q);
    assert_perr_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && fin && res_code == RC_PERR) |=> frozen_q);
    assert_lpm_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && fin && (res_code == RC_LPM_HS || res_code == RC_LPM_TMO)) |=> frozen_q);
    assert_defer_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && sw_freeze && busy_q && !res_valid) |=> !frozen_q);
    assert_pend_applies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && pend_q && fin) |=> frozen_q);
    assert_nak_retries_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && fin && res_code == RC_NAK && !pend_q && !sw_freeze) |=> (!frozen_q && !busy_q));
    assert_stray_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && !busy_q && res_valid && !sw_freeze && !sw_unfreeze) |=> $stable(frozen_q));
endmodule

// File: rtl/upipe_ctrl.sv
// Top of the host pipe controller: bank pointer, per-bank slots and freeze control.
// Assumes: dual_bank is quasi-static; with it low only bank 0 is used.
module upipe_ctrl
    import upipe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_en,
    input  logic                 dual_bank,
    input  logic [MAX_BANKS-1:0] bank_rdy_set,
    input  logic [MAX_BANKS-1:0] done_clr,
    input  logic                 sw_freeze,
    input  logic                 sw_unfreeze,
    input  logic                 tok_grant,
    input  logic                 res_valid,
    input  logic [RES_W-1:0]     res_code,
    output logic                 tok_req,
    output logic [BANK_IDX_W-1:0] cur_bank,
    output logic                 frozen,
    output logic [MAX_BANKS-1:0] bank_rdy,
    output logic [MAX_BANKS-1:0] bank_done
);
    logic [BANK_IDX_W-1:0] bank_q;
    logic                  xfer_ack;
    logic [MAX_BANKS-1:0]  rdy_w, done_w;

    // Bank pointer: advances on every acknowledged transfer in two-bank mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !pipe_en || !dual_bank) bank_q <= '0;
        else if (xfer_ack)                    bank_q <= bank_q + 1'b1;
    end

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        upipe_bank_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .pipe_en  (pipe_en),
            .set_rdy  (bank_rdy_set[b]),
            .consume  (xfer_ack && (bank_q == BANK_IDX_W'(b))),
            .clr_done (done_clr[b]),
            .rdy      (rdy_w[b]),
            .done     (done_w[b])
        );
    end

    upipe_freeze_ctl u_frz (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_en     (pipe_en),
        .bank_ready  (rdy_w[bank_q]),
        .tok_grant   (tok_grant),
        .res_valid   (res_valid),
        .res_code    (res_code),
        .sw_freeze   (sw_freeze),
        .sw_unfreeze (sw_unfreeze),
        .tok_req     (tok_req),
        .frozen      (frozen),
        .xfer_ack    (xfer_ack)
    );

    assign cur_bank  = bank_q;
    assign bank_rdy  = rdy_w;
    assign bank_done = done_w;

    assert_single_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dual_bank) |-> (cur_bank == '0));
    assert_dual_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && dual_bank && xfer_ack) |=> (cur_bank != $past(cur_bank)));
    assert_req_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tok_req |-> bank_rdy[cur_bank]);
endmodule

// File: tb/tb_upipe_ctrl.sv
module tb_upipe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pipe_en, dual_bank, sw_freeze, sw_unfreeze, tok_grant, res_valid;
    logic [1:0] bank_rdy_set, done_clr;
    logic [2:0] res_code;
    logic       tok_req, cur_bank, frozen;
    logic [1:0] bank_rdy, bank_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Model state
    bit       m_frz, m_busy, m_pend, m_bank;
    bit [1:0] m_rdy, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    upipe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .dual_bank(dual_bank),
        .bank_rdy_set(bank_rdy_set), .done_clr(done_clr), .sw_freeze(sw_freeze),
        .sw_unfreeze(sw_unfreeze), .tok_grant(tok_grant), .res_valid(res_valid),
        .res_code(res_code), .tok_req(tok_req), .cur_bank(cur_bank), .frozen(frozen),
        .bank_rdy(bank_rdy), .bank_done(bank_done)
    );

    function automatic bit exp_req();
        return pipe_en && !m_frz && !m_busy && m_rdy[m_bank];
    endfunction

    function automatic bit is_hw_freeze(input logic [2:0] c);
        return (c == 3'd2) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
    endfunction

    task automatic model_next();
        bit fin, ack, start, bnx, frz_now, ob;
        if (!rst_n || !pipe_en) begin
            m_frz = 1; m_busy = 0; m_pend = 0; m_bank = 0; m_rdy = 0; m_done = 0;
            return;
        end
        fin     = m_busy && res_valid;
        ack     = fin && res_code == 3'd0;
        start   = exp_req() && tok_grant;
        bnx     = start || (m_busy && !fin);
        frz_now = (fin && is_hw_freeze(res_code)) || (fin && m_pend) || (sw_freeze && !bnx);
        m_pend  = fin ? 1'b0 : (m_pend || (sw_freeze && bnx));
        m_busy  = bnx;
        if (frz_now) m_frz = 1;
        else if (sw_unfreeze) m_frz = 0;
        ob = m_bank;
        for (int b = 0; b < 2; b++) begin
            if (bank_rdy_set[b]) m_rdy[b] = 1;
            else if (ack && ob == b[0]) m_rdy[b] = 0;
            if (ack && ob == b[0]) m_done[b] = 1;
            else if (done_clr[b]) m_done[b] = 0;
        end
        if (!dual_bank) m_bank = 0;
        else if (ack) m_bank = ~ob;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (tok_req !== exp_req() || frozen !== m_frz || cur_bank !== m_bank ||
            bank_rdy !== m_rdy || bank_done !== m_done) begin
            fails++;
            $display("FAIL %s: req/frz/bank/rdy/done got %b/%b/%b/%b/%b expected %b/%b/%b/%b/%b",
                     tag, tok_req, frozen, cur_bank, bank_rdy, bank_done,
                     exp_req(), m_frz, m_bank, m_rdy, m_done);
        end
    endtask

    // Apply current inputs across one clock edge and check all outputs after it.
    task automatic step(input string tag);
        model_next();
        @(posedge clk);
        #1;
        compare(tag);
        @(negedge clk);
        bank_rdy_set = 0; done_clr = 0; sw_freeze = 0; sw_unfreeze = 0;
        tok_grant = 0; res_valid = 0; res_code = 0;
    endtask

    task automatic xfer(input logic [2:0] code, input string tag);
        tok_grant = 1; step({tag, " grant"});
        res_valid = 1; res_code = code; step({tag, " result"});
    endtask

    initial begin
        int unsigned seed;
        int unsigned r;
        seed = 32'h5eed_1234;
        r = $urandom(seed);
        rst_n = 0; pipe_en = 0; dual_bank = 1;
        bank_rdy_set = 0; done_clr = 0; sw_freeze = 0; sw_unfreeze = 0;
        tok_grant = 0; res_valid = 0; res_code = 0;
        @(negedge clk);
        step("R2 reset");
        step("R2 reset");
        rst_n = 1;
        pipe_en = 1; step("R2 enable frozen");
        bank_rdy_set = 2'b01; step("R1 ready but frozen");
        sw_unfreeze = 1; step("R6 unfreeze / R1 request");
        tok_grant = 1; step("R1 outstanding");
        res_valid = 1; res_code = 3'd1; step("R8 NAK retry");
        xfer(3'd0, "R7 R9 ACK bank0");
        step("R9 waits for bank1");
        bank_rdy_set = 2'b11; step("R9 bank1 ready");
        tok_grant = 1; step("R6 grant");
        sw_freeze = 1; step("R6 freeze deferred");
        step("R6 still outstanding");
        res_valid = 1; res_code = 3'd0; step("R6 freeze applied");
        sw_unfreeze = 1; step("R6 unfreeze");
        xfer(3'd2, "R3 STALL");
        sw_unfreeze = 1; step("R3 unfreeze");
        xfer(3'd3, "R4 pipe error");
        sw_unfreeze = 1; step("R4 unfreeze");
        xfer(3'd4, "R5 LPM handshake");
        sw_unfreeze = 1; step("R5 unfreeze");
        xfer(3'd5, "R5 LPM timeout");
        res_valid = 1; res_code = 3'd2; step("R11 stray while frozen");
        sw_unfreeze = 1; step("R11 unfreeze");
        res_valid = 1; res_code = 3'd0; step("R11 stray ACK idle");
        sw_freeze = 1; step("R6 idle freeze");
        dual_bank = 0; sw_unfreeze = 1; bank_rdy_set = 2'b11; step("R10 single");
        xfer(3'd0, "R10 ACK single");
        bank_rdy_set = 2'b01; step("R10 ready again");
        xfer(3'd0, "R10 ACK single 2");
        done_clr = 2'b11; step("R7 done clear");
        bank_rdy_set = 2'b01; dual_bank = 1; step("R7 set");
        tok_grant = 1; step("R7 grant");
        res_valid = 1; res_code = 3'd0; bank_rdy_set = 2'b01; step("R7 set wins");
        pipe_en = 0; step("R2 disable");
        pipe_en = 1; step("R2 re-enable frozen");

        for (int i = 0; i < 6000; i++) begin
            r = $urandom;
            pipe_en      = (r[6:0] != 0);
            if (r[15:8] == 0) dual_bank = ~dual_bank;
            bank_rdy_set = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
            done_clr     = {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)};
            sw_freeze    = ($urandom_range(0, 19) == 0);
            sw_unfreeze  = ($urandom_range(0, 5) == 0);
            tok_grant    = r[16];
            res_valid    = ($urandom_range(0, 2) == 0);
            r = $urandom_range(0, 15);
            res_code     = (r < 7) ? 3'd0 : (r < 11) ? 3'd1 : 3'($urandom_range(2, 7));
            step("RND R1 R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule